// File: doc/BRIEF.md
# Calibrated Code-to-Temperature Converter

This block turns a raw 12-bit thermal sensor code into a signed temperature in millidegrees Celsius. It uses a straight line fitted through two factory trim codes: one taken at the lower reference temperature of −41 °C and one at the upper reference of 126 °C. It can also run the mapping backwards, from a temperature to the sensor code the die would report at that temperature. A pair of such codes forms the low and high limits of a window comparator. Every quotient comes from one shared sequential signed divider, which resolves one quotient bit per clock.

The caller supplies both trim codes, a mode, and one or two operands, then pulses a start input. When the work finishes, one result (or a pair of results) appears together with a single-cycle done strobe. A trim pair that cannot define a line is refused, as is a mode that is not defined or a limit pair in the wrong order. A refused request raises a single-cycle error strobe in place of done. The block does not fetch the trim codes itself and does not drive any bus.

Top module: `thermo_code_conv`

## Requirements
- R1: In mode 0 (forward), the block returns `result_a_o` = 167000·(code − trim_lo)/(trim_hi − trim_lo) − 41000. The code is the low 12 bits of `op_a_i`, and the division truncates toward zero. `result_b_o` is 0 in this mode.
- R2: A forward result is clamped into the range −41000 to 126000, and both ends of the range apply.
- R3: In mode 1 (inverse), the block returns `result_a_o` = (T + 41000)·(trim_hi − trim_lo)/167000 + trim_lo. T is the signed value of `op_a_i`, and the division truncates toward zero. `result_b_o` is 0 in this mode.
- R4: An inverse result is clamped into the range 0 to 4095.
- R5: A start is refused when the trim pair is invalid, meaning either trim is 0, either trim is 4095, or the two are equal. A refused start pulses `cal_err_o` for one cycle, gives no done strobe, and leaves both results unchanged.
- R6: In mode 2 (limit pair), `op_a_i` and `op_b_i` are temperatures, and each is converted as in R3 and R4, into `result_a_o` and `result_b_o` respectively. The start is refused with `cal_err_o` unless `op_a_i` is less than `op_b_i` as signed values.
- R7: `done_o` is high for exactly one cycle per accepted start. The results change only in the cycle in which `done_o` rises and hold their values otherwise.
- R8: Changes on `start_i`, the mode, the operands and the trims while a conversion is in progress have no effect on it or on its result.
- R9: Mode 3 is reserved, and a start in mode 3 is refused with `cal_err_o`.
- R10: After reset, `done_o` and `cal_err_o` are low and both results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trim_lo_i | input | 12 | Trim code taken at −41 °C |
| trim_hi_i | input | 12 | Trim code taken at 126 °C |
| mode_i | input | 2 | 0 forward, 1 inverse, 2 limit pair, 3 reserved |
| start_i | input | 1 | Request a conversion; it is acted on only when the block is idle |
| op_a_i | input | 32 | Sensor code (forward) or signed temperature in m°C |
| op_b_i | input | 32 | Upper temperature in m°C (limit pair mode) |
| result_a_o | output | 32 | Signed first result |
| result_b_o | output | 32 | Signed second result (limit pair mode), 0 in other modes |
| done_o | output | 1 | One-cycle strobe when the results are valid |
| cal_err_o | output | 1 | One-cycle strobe when a start is refused |

## Verification
The hardest case to reach from the ports is a start that arrives while a conversion is in progress, together with new trims that would be invalid. The stimulus sends a second start of a different mode, with zeroed trims, a few cycles after the first start. It then expects the first result unchanged and no error strobe. Truncation toward zero on a negative quotient is also hard to see, because in forward mode a negative quotient is always clamped away. It shows only in inverse mode, for a temperature a little below −41 °C, where a truncated −1 and a floored −2 give different codes. Trim pairs with a falling slope exercise the sign handling of the divisor.

// File: rtl/cvt_pkg.sv
`timescale 1ns/1ps
package cvt_pkg;

  typedef enum logic [1:0] {
    MODE_FWD  = 2'd0,
    MODE_INV  = 2'd1,
    MODE_LIM  = 2'd2,
    MODE_RSVD = 2'd3
  } mode_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } state_t;

  localparam int CVT_CODE_W  = 12;
  localparam int CVT_RES_W   = 32;
  localparam int CVT_NUM_W   = 64;
  localparam int CVT_DEN_W   = 32;
  localparam int CVT_T_LO_MC = -41000;
  localparam int CVT_T_HI_MC = 126000;

endpackage

// File: rtl/cvt_trim_check.sv
`timescale 1ns/1ps
module cvt_trim_check #(
  parameter int CODE_W = 12
) (
  input  logic [CODE_W-1:0] trim_lo,
  input  logic [CODE_W-1:0] trim_hi,
  output logic              bad
);
  localparam logic [CODE_W-1:0] ALL_ONES = '1;

  logic [1:0] extreme;

  for (genvar i = 0; i < 2; i++) begin : g_trim
    logic [CODE_W-1:0] t;
    assign t = (i == 0) ? trim_lo : trim_hi;
    assign extreme[i] = (t == '0) || (t == ALL_ONES);
  end

  assign bad = (|extreme) || (trim_lo == trim_hi);

endmodule

// File: rtl/cvt_numgen.sv
`timescale 1ns/1ps
module cvt_numgen
  import cvt_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int RES_W   = 32,
  parameter int NUM_W   = 64,
  parameter int DEN_W   = 32,
  parameter int T_LO_MC = -41000,
  parameter int T_HI_MC = 126000
) (
  input  mode_t                    mode,
  input  logic signed [RES_W-1:0]  operand,
  input  logic [CODE_W-1:0]        trim_lo,
  input  logic [CODE_W-1:0]        trim_hi,
  output logic signed [NUM_W-1:0]  num,
  output logic signed [DEN_W-1:0]  den
);
  localparam int SPAN = T_HI_MC - T_LO_MC;
  localparam logic signed [NUM_W-1:0] SPAN_N = NUM_W'(SPAN);
  localparam logic signed [NUM_W-1:0] LO_N   = NUM_W'(T_LO_MC);

  logic signed [NUM_W-1:0] code_n, temp_n, t0_n, t1_n, slope_n;

  always_comb begin
    code_n  = NUM_W'(operand[CODE_W-1:0]);
    temp_n  = NUM_W'(operand);
    t0_n    = NUM_W'(trim_lo);
    t1_n    = NUM_W'(trim_hi);
    slope_n = t1_n - t0_n;
    if (mode == MODE_FWD) begin
      num = SPAN_N * (code_n - t0_n);
      den = DEN_W'(slope_n);
    end else begin
      num = (temp_n - LO_N) * slope_n;
      den = DEN_W'(SPAN_N);
    end
  end

endmodule

// File: rtl/cvt_divider.sv
`timescale 1ns/1ps
module cvt_divider #(
  parameter int NUM_W = 64,
  parameter int DEN_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     go,
  input  logic signed [NUM_W-1:0]  num,
  input  logic signed [DEN_W-1:0]  den,
  output logic signed [NUM_W-1:0]  quo,
  output logic                     fin
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] acc;
  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] dvs;
  logic [CNT_W-1:0] cnt;
  logic             neg;
  logic             run;

  logic [NUM_W-1:0] num_mag;
  logic [DEN_W-1:0] den_mag;
  logic [DEN_W:0]   shifted;
  logic             fits;

  always_comb begin
    num_mag = num[NUM_W-1] ? NUM_W'(-num) : NUM_W'(num);
    den_mag = den[DEN_W-1] ? DEN_W'(-den) : DEN_W'(den);
    shifted = {rem, acc[NUM_W-1]};
    fits    = (shifted >= {1'b0, dvs});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      rem <= '0;
      dvs <= '0;
      cnt <= '0;
      neg <= 1'b0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        acc <= num_mag;
        rem <= '0;
        dvs <= den_mag;
        cnt <= CNT_W'(NUM_W);
        neg <= num[NUM_W-1] ^ den[DEN_W-1];
        run <= 1'b1;
      end else if (run) begin
        rem <= fits ? DEN_W'(shifted - {1'b0, dvs}) : shifted[DEN_W-1:0];
        acc <= {acc[NUM_W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign quo = neg ? -$signed(acc) : $signed(acc);

endmodule

// File: rtl/cvt_finish.sv
`timescale 1ns/1ps
module cvt_finish
  import cvt_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int RES_W   = 32,
  parameter int NUM_W   = 64,
  parameter int T_LO_MC = -41000,
  parameter int T_HI_MC = 126000
) (
  input  mode_t                    mode,
  input  logic [CODE_W-1:0]        trim_lo,
  input  logic signed [NUM_W-1:0]  quo,
  output logic signed [RES_W-1:0]  result
);
  localparam logic signed [NUM_W-1:0] LO_N   = NUM_W'(T_LO_MC);
  localparam logic signed [NUM_W-1:0] HI_N   = NUM_W'(T_HI_MC);
  localparam logic signed [NUM_W-1:0] CMAX_N = NUM_W'((1 << CODE_W) - 1);

  logic signed [NUM_W-1:0] raw, lim_lo, lim_hi, clamped;

  always_comb begin
    if (mode == MODE_FWD) begin
      raw    = quo + LO_N;
      lim_lo = LO_N;
      lim_hi = HI_N;
    end else begin
      raw    = quo + NUM_W'(trim_lo);
      lim_lo = '0;
      lim_hi = CMAX_N;
    end
    if (raw < lim_lo)      clamped = lim_lo;
    else if (raw > lim_hi) clamped = lim_hi;
    else                   clamped = raw;
    result = RES_W'(clamped);
  end

endmodule

// File: rtl/thermo_code_conv.sv
`timescale 1ns/1ps
module thermo_code_conv
  import cvt_pkg::*;
#(
  parameter int CODE_W  = CVT_CODE_W,
  parameter int RES_W   = CVT_RES_W,
  parameter int NUM_W   = CVT_NUM_W,
  parameter int DEN_W   = CVT_DEN_W,
  parameter int T_LO_MC = CVT_T_LO_MC,
  parameter int T_HI_MC = CVT_T_HI_MC
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CODE_W-1:0]       trim_lo_i,
  input  logic [CODE_W-1:0]       trim_hi_i,
  input  logic [1:0]              mode_i,
  input  logic                    start_i,
  input  logic signed [RES_W-1:0] op_a_i,
  input  logic signed [RES_W-1:0] op_b_i,
  output logic signed [RES_W-1:0] result_a_o,
  output logic signed [RES_W-1:0] result_b_o,
  output logic                    done_o,
  output logic                    cal_err_o
);
  state_t                  st;
  mode_t                   mode_q;
  logic [CODE_W-1:0]       t0_q, t1_q;
  logic signed [RES_W-1:0] opb_q, first_q;

  logic                    busy, cal_bad, reject, div_go, div_fin;
  mode_t                   gen_mode;
  logic signed [RES_W-1:0] gen_op;
  logic [CODE_W-1:0]       gen_t0, gen_t1;
  logic signed [NUM_W-1:0] num, quo;
  logic signed [DEN_W-1:0] den;
  logic signed [RES_W-1:0] fin_val;

  assign busy = (st != ST_IDLE);

  cvt_trim_check #(.CODE_W(CODE_W)) u_trim (
    .trim_lo (trim_lo_i),
    .trim_hi (trim_hi_i),
    .bad     (cal_bad)
  );

  assign reject = cal_bad
               || (mode_i == MODE_RSVD)
               || ((mode_i == MODE_LIM) && (op_a_i >= op_b_i));

  always_comb begin
    if (!busy) begin
      gen_mode = mode_t'(mode_i);
      gen_op   = op_a_i;
      gen_t0   = trim_lo_i;
      gen_t1   = trim_hi_i;
    end else begin
      gen_mode = mode_q;
      gen_op   = opb_q;
      gen_t0   = t0_q;
      gen_t1   = t1_q;
    end
  end

  cvt_numgen #(
    .CODE_W(CODE_W), .RES_W(RES_W), .NUM_W(NUM_W), .DEN_W(DEN_W),
    .T_LO_MC(T_LO_MC), .T_HI_MC(T_HI_MC)
  ) u_numgen (
    .mode    (gen_mode),
    .operand (gen_op),
    .trim_lo (gen_t0),
    .trim_hi (gen_t1),
    .num     (num),
    .den     (den)
  );

  assign div_go = (!busy && start_i && !reject)
               || ((st == ST_FIRST) && div_fin && (mode_q == MODE_LIM));

  cvt_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk (clk),
    .rst (rst),
    .go  (div_go),
    .num (num),
    .den (den),
    .quo (quo),
    .fin (div_fin)
  );

  cvt_finish #(
    .CODE_W(CODE_W), .RES_W(RES_W), .NUM_W(NUM_W),
    .T_LO_MC(T_LO_MC), .T_HI_MC(T_HI_MC)
  ) u_finish (
    .mode    (mode_q),
    .trim_lo (t0_q),
    .quo     (quo),
    .result  (fin_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      mode_q     <= MODE_FWD;
      t0_q       <= '0;
      t1_q       <= '0;
      opb_q      <= '0;
      first_q    <= '0;
      result_a_o <= '0;
      result_b_o <= '0;
      done_o     <= 1'b0;
      cal_err_o  <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      cal_err_o <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_i) begin
            if (reject) begin
              cal_err_o <= 1'b1;
            end else begin
              mode_q <= mode_t'(mode_i);
              t0_q   <= trim_lo_i;
              t1_q   <= trim_hi_i;
              opb_q  <= op_b_i;
              st     <= ST_FIRST;
            end
          end
        end
        ST_FIRST: begin
          if (div_fin) begin
            if (mode_q == MODE_LIM) begin
              first_q <= fin_val;
              st      <= ST_SECOND;
            end else begin
              result_a_o <= fin_val;
              result_b_o <= '0;
              done_o     <= 1'b1;
              st         <= ST_IDLE;
            end
          end
        end
        ST_SECOND: begin
          if (div_fin) begin
            result_a_o <= first_q;
            result_b_o <= fin_val;
            done_o     <= 1'b1;
            st         <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cvt_checker.sv
`timescale 1ns/1ps
module cvt_checker
  import cvt_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int RES_W   = 32,
  parameter int T_LO_MC = -41000,
  parameter int T_HI_MC = 126000
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start_i,
  input logic                    busy,
  input logic                    cal_bad,
  input mode_t                   mode_q,
  input logic                    done_o,
  input logic                    cal_err_o,
  input logic signed [RES_W-1:0] result_a_o,
  input logic signed [RES_W-1:0] result_b_o
);
  localparam int CMAX = (1 << CODE_W) - 1;

  AST_ERR_ON_BAD_TRIM: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy && cal_bad) |=> (cal_err_o && !done_o)); // R5

  AST_NO_DONE_WITH_ERR: assert property (@(posedge clk) disable iff (rst)
    !(done_o && cal_err_o)); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(result_a_o) && $stable(result_b_o))); // R7

  AST_FWD_RANGE: assert property (@(posedge clk) disable iff (rst)
    (done_o && mode_q == MODE_FWD) |->
      (result_a_o >= T_LO_MC && result_a_o <= T_HI_MC)); // R2

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (done_o && mode_q != MODE_FWD) |->
      (result_a_o >= 0 && result_a_o <= CMAX)); // R4

  AST_PAIR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (done_o && mode_q == MODE_LIM) |->
      (result_b_o >= 0 && result_b_o <= CMAX)); // R6

  AST_MODE_KEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mode_q)); // R8

endmodule

bind thermo_code_conv cvt_checker #(
  .CODE_W(CODE_W), .RES_W(RES_W), .T_LO_MC(T_LO_MC), .T_HI_MC(T_HI_MC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .busy       (busy),
  .cal_bad    (cal_bad),
  .mode_q     (mode_q),
  .done_o     (done_o),
  .cal_err_o  (cal_err_o),
  .result_a_o (result_a_o),
  .result_b_o (result_b_o)
);

// File: tb/tb_thermo_code_conv.sv
`timescale 1ns/1ps
module tb_thermo_code_conv;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [11:0]        trim_lo = 12'd1000;
  logic [11:0]        trim_hi = 12'd3000;
  logic [1:0]         mode = 2'd0;
  logic               start = 1'b0;
  logic signed [31:0] op_a = '0;
  logic signed [31:0] op_b = '0;
  logic signed [31:0] result_a_o, result_b_o;
  logic               done_o, cal_err_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic    seen_done, seen_err, after_pulse;
  longint  got_a, got_b;

  always #2 clk = ~clk;

  thermo_code_conv dut (
    .clk        (clk),
    .rst        (rst),
    .trim_lo_i  (trim_lo),
    .trim_hi_i  (trim_hi),
    .mode_i     (mode),
    .start_i    (start),
    .op_a_i     (op_a),
    .op_b_i     (op_b),
    .result_a_o (result_a_o),
    .result_b_o (result_b_o),
    .done_o     (done_o),
    .cal_err_o  (cal_err_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_fwd(input int code, input int t0, input int t1);
    longint q, r;
    q = longint'(167000) * longint'(code - t0) / longint'(t1 - t0);
    r = q - 41000;
    if (r < -41000) r = -41000;
    if (r > 126000) r = 126000;
    return r;
  endfunction

  function automatic longint exp_inv(input int temp, input int t0, input int t1);
    longint q, r;
    q = (longint'(temp) + 41000) * longint'(t1 - t0) / longint'(167000);
    r = q + t0;
    if (r < 0) r = 0;
    if (r > 4095) r = 4095;
    return r;
  endfunction

  task automatic run_op(input logic [1:0] m, input int a, input int b,
                        input int t0, input int t1);
    @(negedge clk);
    mode = m; op_a = a; op_b = b;
    trim_lo = t0[11:0]; trim_hi = t1[11:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 400; n++) begin
      if (done_o || cal_err_o) break;
      @(negedge clk);
    end
    seen_done = done_o;
    seen_err  = cal_err_o;
    got_a     = longint'(result_a_o);
    got_b     = longint'(result_b_o);
    @(negedge clk);
    after_pulse = done_o | cal_err_o;
  endtask

  task automatic fwd_case(input string tag, input int code, input int t0, input int t1);
    run_op(2'd0, code, 0, t0, t1);
    chk({tag, " done"}, seen_done, 1);
    chk({tag, " no err"}, seen_err, 0);
    chk({tag, " result_a"}, got_a, exp_fwd(code, t0, t1));
    chk({tag, " result_b zero"}, got_b, 0);
  endtask

  task automatic inv_case(input string tag, input int temp, input int t0, input int t1);
    run_op(2'd1, temp, 0, t0, t1);
    chk({tag, " done"}, seen_done, 1);
    chk({tag, " result_a"}, got_a, exp_inv(temp, t0, t1));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 done low", done_o, 0);
    chk("R10 err low", cal_err_o, 0);
    chk("R10 result_a zero", longint'(result_a_o), 0);
    chk("R10 result_b zero", longint'(result_b_o), 0);
    rst = 1'b0;
  endtask

  task automatic t_forward;
    fwd_case("R1 mid", 2000, 1000, 3000);
    chk("R7 done single cycle", after_pulse, 0);
    fwd_case("R1 near low trim", 1001, 1000, 3000);
    chk("R1 exact value", got_a, -40917);
    fwd_case("R1 near high trim", 2999, 1000, 3000);
    fwd_case("R1 falling slope", 2001, 3000, 1000);
    chk("R1 falling slope value", got_a, 42416);
  endtask

  task automatic t_fwd_clamp;
    fwd_case("R2 above top", 4000, 1000, 3000);
    chk("R2 top value", got_a, 126000);
    fwd_case("R2 below bottom", 500, 1000, 3000);
    chk("R2 bottom value", got_a, -41000);
    fwd_case("R2 zero code", 0, 1000, 3000);
  endtask

  task automatic t_inverse;
    inv_case("R3 mid", 42500, 1000, 3000);
    chk("R3 mid value", got_a, 2000);
    inv_case("R3 trunc toward zero", -41100, 1000, 3000);
    chk("R3 trunc value", got_a, 999);
    inv_case("R3 low ref", -41000, 1000, 3000);
    inv_case("R3 high ref", 126000, 1000, 3000);
    inv_case("R3 falling slope", 0, 3000, 1000);
    chk("R3 falling slope value", got_a, 2509);
    chk("R3 result_b zero", got_b, 0);
  endtask

  task automatic t_inv_clamp;
    inv_case("R4 high clamp", 500000, 1000, 3000);
    chk("R4 high value", got_a, 4095);
    inv_case("R4 low clamp", -200000, 1000, 3000);
    chk("R4 low value", got_a, 0);
  endtask

  task automatic bad_case(input string tag, input int t0, input int t1);
    run_op(2'd0, 2000, 0, t0, t1);
    chk({tag, " err"}, seen_err, 1);
    chk({tag, " no done"}, seen_done, 0);
    chk({tag, " result held"}, got_a, 42500);
    chk({tag, " single pulse"}, after_pulse, 0);
  endtask

  task automatic t_bad_trim;
    fwd_case("R5 setup", 2000, 1000, 3000);
    bad_case("R5 low trim zero", 0, 3000);
    bad_case("R5 high trim zero", 1000, 0);
    bad_case("R5 low trim full", 4095, 3000);
    bad_case("R5 high trim full", 1000, 4095);
    bad_case("R5 equal trims", 1500, 1500);
  endtask

  task automatic t_limits;
    run_op(2'd2, 20000, 80000, 1000, 3000);
    chk("R6 pair done", seen_done, 1);
    chk("R6 pair low code", got_a, exp_inv(20000, 1000, 3000));
    chk("R6 pair high code", got_b, exp_inv(80000, 1000, 3000));
    chk("R6 pair single done", after_pulse, 0);
    run_op(2'd2, 50000, 50000, 1000, 3000);
    chk("R6 equal refused", seen_err, 1);
    chk("R6 equal no done", seen_done, 0);
    run_op(2'd2, 90000, 10000, 1000, 3000);
    chk("R6 reversed refused", seen_err, 1);
    chk("R6 reversed results held", got_b, exp_inv(80000, 1000, 3000));
  endtask

  task automatic t_reserved;
    run_op(2'd3, 2000, 0, 1000, 3000);
    chk("R9 reserved err", seen_err, 1);
    chk("R9 reserved no done", seen_done, 0);
  endtask

  task automatic t_busy;
    logic errs, dn;
    @(negedge clk);
    mode = 2'd0; op_a = 2000; trim_lo = 12'd1000; trim_hi = 12'd3000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    mode = 2'd1; op_a = 5; trim_lo = 12'd0; trim_hi = 12'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    errs = 1'b0; dn = 1'b0;
    for (int n = 0; n < 400; n++) begin
      if (cal_err_o) errs = 1'b1;
      if (done_o) begin dn = 1'b1; break; end
      @(negedge clk);
    end
    chk("R8 first op completes", dn, 1);
    chk("R8 first op result", longint'(result_a_o), 42500);
    chk("R8 no error from ignored start", errs, 0);
    dn = 1'b0;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if (done_o || cal_err_o) dn = 1'b1;
    end
    chk("R8 ignored start left no work", dn, 0);
    trim_lo = 12'd1000; trim_hi = 12'd3000;
  endtask

  initial begin
    t_reset();
    t_forward();
    t_fwd_clamp();
    t_inverse();
    t_inv_clamp();
    t_bad_trim();
    t_limits();
    t_reserved();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule